// File: doc/BRIEF.md
# Multi-Phase Sampling Time-to-Digital Converter

This block timestamps the rising edges of asynchronous discriminator outputs on a set of channels (16 by default) to a quarter of a reference clock period. Every hit line is captured by four copies of the reference clock. The copies are 0°, 90°, 180° and 270° apart. The four captures are moved into the 0° domain through a register chain for each phase. Once there, they form a 4-bit thermometer pattern for each coarse cycle. A free-running coarse counter supplies the upper part of the time. The pattern supplies a 2-bit fine part. With a 250 MHz reference this gives 4 ns coarse bins and 1 ns fine bins.

Only leading edges are recorded. Each channel holds a detected edge in a pending slot. A priority stage writes the pending slots into one shared FIFO, one word per reference cycle, lowest channel first. The readout side sees the head word whenever the FIFO is not empty. If the FIFO is full, new words are lost and a sticky overflow indicator is set.

Top module: `multi_phase_tdc`

## Requirements
- R1: After reset, `rd_valid` and `overflow` are 0 and the FIFO holds no words.
- R2: Let E be a rising edge of phase 0. A hit arriving in the quarter-period slot k after E (k = 1, 2, 3) gets fine time k. A hit arriving in the last quarter before E gets fine time 0. That case shows as pattern 1111 (bit 3 = 0° sample, bit 0 = 270° sample) after a cycle whose 270° sample was 0. A pattern of 0111 gives 1, 0011 gives 2 and 0001 gives 3.
- R3: The coarse field equals the number of phase-0 rising edges since reset release, counted up to and including E.
- R4: A FIFO word is {channel[21:18], coarse[17:2], fine[1:0]}.
- R5: A hit that stays high for several cycles produces exactly one word. A new rising edge after the line has been low for a full cycle produces another word.
- R6: Edges from several channels in the same cycle are written one per cycle in ascending channel order.
- R7: The coarse field wraps from 16'hFFFF to 0 with no other effect.
- R8: A word arriving while the FIFO is full is dropped and `overflow` is raised. The words already stored are read back unchanged.
- R9: `overflow` stays 1 through reads and is cleared only by reset.
- R10: `rd_data` shows the oldest word while `rd_valid` is 1. A cycle with `rd_en` high removes that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ph | input | 4 | Reference clock copies; bit k lags bit 0 by k quarter periods |
| rst | input | 1 | Asynchronous active-high reset |
| hit_in | input | 16 | Asynchronous discriminator hit lines |
| rd_en | input | 1 | Remove the head word (phase-0 domain) |
| rd_data | output | 22 | Head word {channel, coarse, fine} |
| rd_valid | output | 1 | FIFO holds at least one word |
| overflow | output | 1 | Sticky: a word was lost to a full FIFO |

## Verification
The hardest case to produce is a hit just before the 0° edge. Its whole 1111 pattern falls into one window, and only the previous window's 270° sample shows that the edge is new. The bench places hit transitions at fixed offsets from the phase-0 edge. Those offsets lie between the phase edges, so each one lands in a known quarter. The offset 2 ns before the edge reaches this case. Other cases need long waits or withheld reads: the bench waits about 65 000 cycles for the coarse wrap, and it holds reads off while all sixteen channels fire at once to fill the FIFO.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
   // Default geometry shared by the TDC modules.
   localparam int unsigned DEF_CHANNELS    = 16;
   localparam int unsigned DEF_PHASES      = 4;
   localparam int unsigned DEF_COARSE_W    = 16;
   localparam int unsigned DEF_SYNC_STAGES = 2;
   localparam int unsigned DEF_FIFO_DEPTH  = 8;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tdc_phase_capture.sv
`timescale 1ns/1ps
// One channel: capture a hit on every phase clock, then carry each capture
// into the phase-0 domain through SYNC_STAGES registers.
module tdc_phase_capture #(
   parameter int unsigned NPH         = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic [NPH-1:0] clk_ph,
   input  logic           rst,
   input  logic           hit,
   output logic [NPH-1:0] pattern   // bit NPH-1 = phase 0 sample
);
   for (genvar k = 0; k < NPH; k++) begin : g_phase
      logic                   cap;
      logic [SYNC_STAGES-1:0] chain;

      always_ff @(posedge clk_ph[k] or posedge rst) begin
         if (rst) cap <= 1'b0;
         else     cap <= hit;
      end

      always_ff @(posedge clk_ph[0] or posedge rst) begin
         if (rst) chain <= '0;
         else     chain <= {chain[SYNC_STAGES-2:0], cap};
      end

      assign pattern[NPH-1-k] = chain[SYNC_STAGES-1];
   end
endmodule

// File: rtl/tdc_edge_encoder.sv
`timescale 1ns/1ps
// Converts an aligned thermometer pattern into a leading-edge flag and a
// fine time equal to the index of the earliest phase that saw the hit.
module tdc_edge_encoder #(
   parameter int unsigned NPH    = 4,
   parameter int unsigned FINE_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NPH-1:0]    pattern,
   output logic              hit_edge,
   output logic [FINE_W-1:0] fine_o
);
   logic last_was_high;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) last_was_high <= 1'b0;
      else     last_was_high <= pattern[0];
   end

   always_comb begin
      fine_o = '0;
      for (int k = NPH - 1; k >= 0; k--) begin
         if (pattern[NPH-1-k]) fine_o = FINE_W'(k);
      end
   end

   assign hit_edge = (pattern != '0) && !last_was_high;

   // R5
   single_edge_chk: assert property (@(posedge clk) disable iff (rst)
      (hit_edge && pattern[0]) |=> !hit_edge);
endmodule

// File: rtl/tdc_hit_arbiter.sv
`timescale 1ns/1ps
// Per-channel pending slot plus a lowest-index-first selector feeding one
// write port.
module tdc_hit_arbiter #(
   parameter int unsigned NCH = 16,
   parameter int unsigned W   = 22
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [NCH-1:0] edge_in,
   input  logic [W-1:0]   word_in [NCH],
   output logic           wr_req,
   output logic [W-1:0]   wr_word
);
   localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

   logic [NCH-1:0]   pending;
   logic [NCH-1:0]   grant;
   logic [NCH-1:0]   accept;
   logic [IDX_W-1:0] sel;
   logic [W-1:0]     held [NCH];

   always_comb begin
      sel   = '0;
      grant = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (pending[i]) sel = IDX_W'(i);
      end
      if (|pending) grant[sel] = 1'b1;
      accept = edge_in & (~pending | grant);
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) pending <= '0;
      else     pending <= (pending & ~grant) | accept;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_slot
      always_ff @(posedge clk) begin
         if (accept[c]) held[c] <= word_in[c];
      end

      // R6
      grant_clears_chk: assert property (@(posedge clk) disable iff (rst)
         (grant[c] && !edge_in[c]) |=> !pending[c]);
   end

   assign wr_req  = |pending;
   assign wr_word = held[sel];
endmodule

// File: rtl/tdc_hit_fifo.sv
`timescale 1ns/1ps
// Show-ahead synchronous FIFO with drop-on-full and a sticky loss flag.
module tdc_hit_fifo #(
   parameter int unsigned W     = 22,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_req,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         rd_valid,
   output logic         overflow
);
   localparam int unsigned AW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [AW:0]   count;
   logic          full, do_wr, do_rd;

   assign full     = (count == (AW+1)'(DEPTH));
   assign rd_valid = (count != '0);
   assign do_wr    = wr_req && !full;
   assign do_rd    = rd_en && rd_valid;
   assign rd_data  = mem[rptr];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         wptr     <= '0;
         rptr     <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         count    <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
         overflow <= overflow | (wr_req && full);
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wr_data;
   end

   // R9
   overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);
   // R8
   drop_when_full_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_req && full && !rd_en) |=> ($stable(count) && overflow));
   // R10
   read_pops_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_valid && !wr_req) |=> (count == $past(count) - 1'b1));
   // R10
   count_bound_chk: assert property (@(posedge clk) disable iff (rst)
      count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/multi_phase_tdc.sv
`timescale 1ns/1ps
module multi_phase_tdc
   import tdc_pkg::*;
#(
   parameter  int unsigned NCH         = DEF_CHANNELS,
   parameter  int unsigned NPH         = DEF_PHASES,
   parameter  int unsigned COARSE_W    = DEF_COARSE_W,
   parameter  int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
   parameter  int unsigned FIFO_DEPTH  = DEF_FIFO_DEPTH,
   localparam int unsigned CH_W        = $clog2(NCH),
   localparam int unsigned FINE_W      = $clog2(NPH),
   localparam int unsigned WORD_W      = CH_W + COARSE_W + FINE_W
) (
   input  logic [NPH-1:0]    clk_ph,
   input  logic              rst,
   input  logic [NCH-1:0]    hit_in,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              overflow
);
   // Elaboration-time parameter checks.
   if (NPH < 2 || !is_pow2(NPH)) begin : g_bad_nph
      $error("NPH must be a power of two, at least 2");
   end
   if (NCH < 2 || !is_pow2(NCH)) begin : g_bad_nch
      $error("NCH must be a power of two, at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FIFO_DEPTH < 2 || !is_pow2(FIFO_DEPTH)) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end
   if (COARSE_W <= $clog2(SYNC_STAGES + 1)) begin : g_bad_coarse
      $error("COARSE_W too small for the alignment latency");
   end

   logic                clk;
   logic [COARSE_W-1:0] coarse_cnt;
   logic [COARSE_W-1:0] stamp;
   logic [NCH-1:0]      hit_edge;
   logic [FINE_W-1:0]   fine   [NCH];
   logic [WORD_W-1:0]   words  [NCH];
   logic                wr_req;
   logic [WORD_W-1:0]   wr_word;

   assign clk = clk_ph[0];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) coarse_cnt <= '0;
      else     coarse_cnt <= coarse_cnt + 1'b1;
   end

   // The encoder sees the window that opened SYNC_STAGES cycles earlier.
   assign stamp = coarse_cnt - COARSE_W'(SYNC_STAGES);

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic [NPH-1:0] pattern;

      tdc_phase_capture #(.NPH(NPH), .SYNC_STAGES(SYNC_STAGES)) cap_i (
         .clk_ph  (clk_ph),
         .rst     (rst),
         .hit     (hit_in[c]),
         .pattern (pattern)
      );

      tdc_edge_encoder #(.NPH(NPH), .FINE_W(FINE_W)) enc_i (
         .clk      (clk),
         .rst      (rst),
         .pattern  (pattern),
         .hit_edge (hit_edge[c]),
         .fine_o   (fine[c])
      );

      assign words[c] = {CH_W'(c), stamp, fine[c]};
   end

   tdc_hit_arbiter #(.NCH(NCH), .W(WORD_W)) arb_i (
      .clk     (clk),
      .rst     (rst),
      .edge_in (hit_edge),
      .word_in (words),
      .wr_req  (wr_req),
      .wr_word (wr_word)
   );

   tdc_hit_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk      (clk),
      .rst      (rst),
      .wr_req   (wr_req),
      .wr_data  (wr_word),
      .rd_en    (rd_en),
      .rd_data  (rd_data),
      .rd_valid (rd_valid),
      .overflow (overflow)
   );

   // R7
   coarse_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (coarse_cnt == '1) |=> (coarse_cnt == '0));
endmodule

// File: tb/multi_phase_tdc_tb_top.sv
`timescale 1ns/1ps
module multi_phase_tdc_tb_top;
   localparam int NCH   = 16;
   localparam int DEPTH = 8;
   localparam int W     = 22;

   logic clk0 = 1'b0, clk1 = 1'b0, clk2 = 1'b0, clk3 = 1'b0;
   logic [3:0]     clk_ph;
   logic           rst;
   logic [NCH-1:0] hit_in;
   logic           rd_en;
   logic [W-1:0]   rd_data;
   logic           rd_valid;
   logic           overflow;

   int             errors = 0;
   int             checks = 0;
   int             bcnt   = 0;
   bit             allow_rd = 1'b0;
   string          cur_req = "R4";
   logic [W-1:0]   exp_q [$];

   assign clk_ph = {clk3, clk2, clk1, clk0};

   // 50 MHz phase 0; the other copies lag by 5, 10 and 15 ns.
   initial forever #10 clk0 = ~clk0;
   initial begin #5;  forever #10 clk1 = ~clk1; end
   initial begin #10; forever #10 clk2 = ~clk2; end
   initial begin #15; forever #10 clk3 = ~clk3; end

   multi_phase_tdc dut_i (
      .clk_ph   (clk_ph),
      .rst      (rst),
      .hit_in   (hit_in),
      .rd_en    (rd_en),
      .rd_data  (rd_data),
      .rd_valid (rd_valid),
      .overflow (overflow)
   );

   // Reference edge count since reset release (R3).
   always @(posedge clk0 or posedge rst) begin
      if (rst) bcnt <= 0;
      else     bcnt <= bcnt + 1;
   end

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic check(input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] fine_of(input int offs);
      if (offs <= 0) return 2'd0;
      return 2'((offs + 4) / 5);
   endfunction

   // Monitor: pop and compare every word the design presents.
   always @(negedge clk0) begin
      if (!rst && allow_rd && rd_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s actual=%h expected=none", cur_req, rd_data);
         end else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            if (rd_data !== e) begin
               errors++;
               $display("FAIL %s actual=%h expected=%h", cur_req, rd_data, e);
            end
         end
         rd_en = 1'b1;
      end else begin
         rd_en = 1'b0;
      end
   end

   // Driver: raise the masked lines at offs ns from the next phase-0 edge,
   // hold them for hold cycles, and queue up to max_push expected words.
   task automatic fire(input logic [NCH-1:0] mask, input int offs,
                       input int hold, input int max_push);
      int base;
      int pushed;
      pushed = 0;
      @(negedge clk0);
      base = bcnt + 1;
      #(10 + offs);
      hit_in = hit_in | mask;
      for (int c = 0; c < NCH; c++) begin
         if (mask[c] && pushed < max_push) begin
            exp_q.push_back({4'(c), 16'(base), fine_of(offs)});
            pushed++;
         end
      end
      repeat (hold) @(negedge clk0);
      hit_in = hit_in & ~mask;
      repeat (3) @(negedge clk0);
   endtask

   task automatic drain;
      for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk0);
      repeat (10) @(negedge clk0);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL %s actual=%0d expected=0 words outstanding",
                  cur_req, exp_q.size());
      end
   endtask

   initial begin
      #3_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      report();
      $finish;
   end

   initial begin
      rst    = 1'b1;
      hit_in = '0;
      repeat (3) @(negedge clk0);
      // R1: reset state
      check("R1", W'(rd_valid), W'(0));
      check("R1", W'(overflow), W'(0));
      rst = 1'b0;
      repeat (2) @(negedge clk0);
      allow_rd = 1'b1;

      // R2 R3 R4: one bin per quarter, including the 1111 case
      cur_req = "R2";
      fire(16'h0001, -2, 2, NCH); drain();
      fire(16'h0002,  2, 2, NCH); drain();
      fire(16'h0004,  7, 2, NCH); drain();
      fire(16'h0008, 12, 2, NCH); drain();
      cur_req = "R3";
      fire(16'h8000, 12, 3, NCH); drain();

      // R5: long hit, then a fresh rise on the same line
      cur_req = "R5";
      fire(16'h0080, 7, 6, NCH);
      fire(16'h0080, 2, 2, NCH); drain();
      check("R5", W'(rd_valid), W'(0));

      // R6: three lines together, expected in ascending order
      cur_req = "R6";
      fire(16'h1208, -2, 2, NCH); drain();

      // R7: coarse wrap
      cur_req = "R7";
      while (bcnt != 65533) @(negedge clk0);
      fire(16'h0020, 2, 2, NCH);
      fire(16'h0040, 7, 2, NCH); drain();

      // R8: fill the FIFO with reads held off
      cur_req = "R8";
      allow_rd = 1'b0;
      fire(16'hFFFF, 7, 2, DEPTH);
      repeat (25) @(negedge clk0);
      check("R8", W'(overflow), W'(1));
      check("R8", W'(rd_valid), W'(1));
      allow_rd = 1'b1;
      drain();

      // R9: flag survives reads, reset clears it
      check("R9", W'(overflow), W'(1));
      check("R10", W'(rd_valid), W'(0));
      rst = 1'b1;
      repeat (2) @(negedge clk0);
      check("R9", W'(overflow), W'(0));
      check("R1", W'(rd_valid), W'(0));
      rst = 1'b0;
      repeat (2) @(negedge clk0);

      report();
      $finish;
   end
endmodule